// File: doc/BRIEF.md
# Interleaved Per-Channel Offset Canceller

This block sits at the front of a correction chain for a time-interleaved converter. Gain and timing stages follow it. It receives the combined sample stream and tags each valid sample with a channel index. The index starts at zero and steps by one, modulo the channel count, on every valid sample. Each channel keeps its own accumulator. When a channel has collected a full window of its own samples, the block turns the sum into a mean and holds it as that channel's DC offset estimate.

Every sample has the held estimate of its own channel subtracted from it. The result is clamped to the signed sample range and sent out one cycle later, together with its channel index. Each channel has a flag that goes high once its first estimate exists. Estimation runs without pause on live data and assumes that the true input averages to zero. With the default window of 32 samples per channel, an estimate settles within a few tens of samples of that channel.

Top module: `offset_canceller`

## Requirements
- R1: After reset the channel index is 0. It advances by one on each cycle where `valid_i` is high and wraps from NUM_CH-1 to 0. `chan_o` carries the index of the sample being output.
- R2: `valid_o` is high exactly one clock after a cycle with `valid_i` high. A cycle with `valid_i` low produces no output, does not advance the index and leaves all estimates unchanged.
- R3: `sample_o` equals the two's-complement raw sample minus the currently held estimate of the sample's channel.
- R4: When the difference leaves the signed DATA_W range, `sample_o` saturates: to 2^(DATA_W-1)-1 (2047 at 12 bits) on positive overflow, and to -2^(DATA_W-1) (-2048) on negative overflow.
- R5: Each channel sums its own samples over a window of N = 2^WIN_LOG2 samples. On the Nth sample the estimate becomes floor(sum/N), an arithmetic right shift, and the sum clears. The Nth sample is still corrected with the previous estimate. The new estimate applies from the channel's next sample onward.
- R6: Reset is asynchronous and active low. It sets every estimate to 0, clears `est_valid_o`, clears `valid_o` and sets the index to 0.
- R7: Bit c of `est_valid_o` belongs to channel c. It rises in the clock that completes channel c's first window and stays high until reset.
- R8: Samples of one channel never change the estimate or the window count of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample present |
| sample_i | input | DATA_W | Raw signed sample |
| valid_o | output | 1 | Corrected sample present |
| sample_o | output | DATA_W | Corrected signed sample, saturated |
| chan_o | output | CH_W | Channel index of the output sample |
| est_valid_o | output | NUM_CH | Per-channel estimate-ready flags |

## Verification
The first stimulus gives each channel a different constant offset with a zero-mean square wave on top. A leak between channels, a wrong channel select, or a mean taken at the wrong moment would each show up as a channel-specific error. Gaps in `valid_i` are scattered through the stream, which separates a design that counts valid samples from one that counts clock cycles.

The flags are checked partway through the first set of windows, when only channel 0 has completed its window. This tells per-channel completion apart from a shared completion. A final phase drives near-full-scale offsets followed by full-scale samples of the opposite sign, which separates clamping from wraparound in both directions.

// File: rtl/offset_canc_pkg.sv
package offset_canc_pkg;
  localparam int unsigned DEF_NUM_CH   = 4;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_WIN_LOG2 = 5;
endpackage

// File: rtl/oc_chan_ctr.sv
module oc_chan_ctr #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [CH_W-1:0] idx_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (adv_i)  idx_q <= (idx_q == LAST) ? '0 : idx_q + CH_W'(1);
  end

  assign idx_o = idx_q;

  a_r1_idx_rotates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + CH_W'(1)));
  a_r2_idx_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/oc_chan_accum.sv
module oc_chan_accum #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned WIN_LOG2 = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     hit_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] est_o,
  output logic                     est_valid_o
);
  localparam int unsigned ACC_W = DATA_W + WIN_LOG2 + 1;

  logic signed [ACC_W-1:0]  acc_q, acc_sum, acc_shr;
  logic [WIN_LOG2-1:0]      cnt_q;
  logic signed [DATA_W-1:0] est_q;
  logic                     ev_q;
  logic                     last_w;

  assign acc_sum = acc_q + ACC_W'(sample_i);
  assign acc_shr = acc_sum >>> WIN_LOG2;
  assign last_w  = (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
      est_q <= '0;
      ev_q  <= 1'b0;
    end else if (hit_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_w) begin
        acc_q <= '0;
        est_q <= acc_shr[DATA_W-1:0];
        ev_q  <= 1'b1;
      end else begin
        acc_q <= acc_sum;
      end
    end
  end

  assign est_o       = est_q;
  assign est_valid_o = ev_q;

  a_r5_window_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && last_w) |=> (ev_q && cnt_q == '0 && acc_q == '0));
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> ($stable(est_q) && $stable(cnt_q) && $stable(acc_q)));
  a_r6_zero_before_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_q |-> est_q == '0);
  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q |=> ev_q);
endmodule

// File: rtl/oc_sat_sub.sv
module oc_sat_sub #(
  parameter int unsigned DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] diff;

  always_comb begin
    diff = {a_i[DATA_W-1], a_i} - {b_i[DATA_W-1], b_i};
    if (diff[DATA_W] != diff[DATA_W-1]) y_o = diff[DATA_W] ? MINV : MAXV;
    else                                y_o = diff[DATA_W-1:0];
  end
endmodule

// File: rtl/offset_canceller.sv
module offset_canceller
  import offset_canc_pkg::*;
#(
  parameter int unsigned NUM_CH   = DEF_NUM_CH,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned WIN_LOG2 = DEF_WIN_LOG2,
  parameter int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sample_o,
  output logic [CH_W-1:0]          chan_o,
  output logic [NUM_CH-1:0]        est_valid_o
);
  logic [CH_W-1:0]          idx;
  logic signed [DATA_W-1:0] est_w [NUM_CH];
  logic signed [DATA_W-1:0] corr;
  logic                     valid_q;
  logic signed [DATA_W-1:0] sample_q;
  logic [CH_W-1:0]          chan_q;

  oc_chan_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (valid_i),
    .idx_o (idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    oc_chan_accum #(.DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2)) u_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (valid_i && (idx == CH_W'(c))),
      .sample_i   (sample_i),
      .est_o      (est_w[c]),
      .est_valid_o(est_valid_o[c])
    );
  end

  oc_sat_sub #(.DATA_W(DATA_W)) u_sub (
    .a_i(sample_i),
    .b_i(est_w[idx]),
    .y_o(corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      sample_q <= '0;
      chan_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        sample_q <= corr;
        chan_q   <= idx;
      end
    end
  end

  assign valid_o  = valid_q;
  assign sample_o = sample_q;
  assign chan_o   = chan_q;

  a_r2_out_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r1_chan_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> chan_o == $past(idx));
endmodule

// File: tb/offset_canceller_test.sv
module offset_canceller_test;
  localparam int NCH  = 4;
  localparam int DW   = 12;
  localparam int WL   = 5;
  localparam int NWIN = 1 << WL;
  localparam int MAXV = (1 << (DW - 1)) - 1;
  localparam int MINV = -(1 << (DW - 1));

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 valid_i = 1'b0;
  logic signed [DW-1:0] sample_i = '0;
  logic                 valid_o;
  logic signed [DW-1:0] sample_o;
  logic [1:0]           chan_o;
  logic [NCH-1:0]       est_valid_o;

  offset_canceller #(.NUM_CH(NCH), .DATA_W(DW), .WIN_LOG2(WL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sample_i(sample_i),
    .valid_o(valid_o), .sample_o(sample_o), .chan_o(chan_o), .est_valid_o(est_valid_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    exp_val_q[$];
  int    exp_ch_q[$];
  string tag_q[$];

  int m_idx;
  int m_acc[NCH];
  int m_cnt[NCH];
  int m_est[NCH];
  bit m_ev[NCH];

  function automatic int sat(int v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic send(int v);
    int ch, d;
    string t;
    @(negedge clk);
    valid_i  = 1'b1;
    sample_i = DW'(v);
    ch = m_idx;
    d = v - m_est[ch];
    if (d != sat(d))  t = "R4";
    else if (!m_ev[ch]) t = "R6/R3";
    else t = "R5/R8/R3";
    exp_val_q.push_back(sat(d));
    exp_ch_q.push_back(ch);
    tag_q.push_back(t);
    m_acc[ch] += v;
    m_cnt[ch]++;
    if (m_cnt[ch] == NWIN) begin
      m_est[ch] = m_acc[ch] >>> WL;
      m_acc[ch] = 0;
      m_cnt[ch] = 0;
      m_ev[ch]  = 1'b1;
    end
    m_idx = (m_idx + 1) % NCH;
    @(posedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic check_ev(logic [NCH-1:0] exp, string req);
    @(negedge clk);
    valid_i = 1'b0;
    checks++;
    if (est_valid_o !== exp) begin
      errors++;
      $display("FAIL %s est_valid_o actual %b expected %b", req, est_valid_o, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o) begin
      checks++;
      if (exp_val_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected valid_o actual 1 expected 0");
      end else begin
        int ev, ec;
        string t;
        ev = exp_val_q.pop_front();
        ec = exp_ch_q.pop_front();
        t  = tag_q.pop_front();
        if (int'(sample_o) != ev) begin
          errors++;
          $display("FAIL %s sample_o actual %0d expected %0d", t, sample_o, ev);
        end
        if (int'(chan_o) != ec) begin
          errors++;
          $display("FAIL R1 chan_o actual %0d expected %0d", chan_o, ec);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int offs[NCH];
    m_idx = 0;
    for (int c = 0; c < NCH; c++) begin
      m_acc[c] = 0; m_cnt[c] = 0; m_est[c] = 0; m_ev[c] = 1'b0;
    end
    offs[0] = 100; offs[1] = -50; offs[2] = 300; offs[3] = -7;

    repeat (3) @(negedge clk);
    // R6: reset state
    checks++;
    if (valid_o !== 1'b0 || est_valid_o !== '0) begin
      errors++;
      $display("FAIL R6 reset outputs actual %b/%b expected 0/0000", valid_o, est_valid_o);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle valid_o actual %b expected 0", valid_o);
    end

    // R5/R7/R8: distinct per-channel offsets, square-wave signal, valid gaps
    for (int s = 0; s < NCH * (NWIN - 1) + 1; s++) begin
      int ch = s % NCH;
      int w  = ((s / NCH) % 2 == 0) ? 200 : -200;
      send(offs[ch] + w);
      if (s % 7 == 3) idle(1);
    end
    check_ev(4'b0001, "R7");
    for (int s = NCH * (NWIN - 1) + 1; s < NCH * NWIN * 3; s++) begin
      int ch = s % NCH;
      int w  = ((s / NCH) % 2 == 0) ? 200 : -200;
      send(offs[ch] + w + (s % 5) - 2);
      if (s % 11 == 5) idle(2);
    end
    check_ev(4'b1111, "R7");

    // R4: saturation in both directions
    for (int s = 0; s < NCH * NWIN; s++) begin
      case (s % NCH)
        0: send(-1900);
        1: send(1900);
        2: send(0);
        default: send(-2048);
      endcase
    end
    send(2047);
    send(-2048);
    send(5);
    send(2047);
    // ramp pattern through all channels
    for (int s = 0; s < NCH * NWIN; s++) send((s * 37) % 1000 - 500);
    idle(4);

    checks++;
    if (exp_val_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing outputs actual %0d pending expected 0", exp_val_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule